// File: doc/BRIEF.md
# 2D Drawing Engine Register File with Launch Control

This block holds the programming state of a 2D drawing engine that serves three command groups: rectangle copy, line and polygon. Each group owns a 256-byte address window for its parameters plus a command page directly above it. The windows start at 0xA4xx, 0xA8xx and 0xACxx, and the command pages at 0xA5xx, 0xA9xx and 0xADxx. Base, clip, stride and pattern registers exist only once and are reached through every window that maps them. The command register is likewise one register seen at three addresses.

Software writes whole dwords. The block masks each write down to the fields the engine uses and stores the packed result. Readback is combinational and returns the stored fields in the same packed layout.

The block also decides when to start the engine and emits a one-cycle launch strobe. If the command word has the auto-execute bit clear, the strobe follows the command write itself. If the bit is set, the strobe waits for the group's final parameter write.

Top module: `gfx2d_regfile`

## Requirements
- R1: After synchronous reset every register reads back as zero and `launch` is low.
- R2: Offset low byte 0xD4 (source base), 0xD8 (destination base), 0xDC (horizontal clip), 0xE0 (vertical clip), 0xE4 (stride) and 0xF4 (pattern foreground) reach one shared register from pages 0xA4, 0xA8 and 0xAC. 0xE8, 0xEC and 0xF0 (mono pattern words and pattern background) are shared by pages 0xA4 and 0xAC only. The command register answers at 0xA500, 0xA900 and 0xAD00.
- R3: A base write is stored ANDed with 0x7FFFF8 when `mem_big` is 1 during the write, and with 0x3FFFF8 otherwise. The stored value keeps that mask when `mem_big` changes later.
- R4: The two clip registers and the three rectangle pair registers keep data bits 26:16 and 10:0, and read back with all other bits zero. The stride register keeps bits 27:16 and 11:0, each ANDed with 0xFF8.
- R5: The auto-execute bit is command bit 0. A command write with bit 0 clear drives `launch` high for exactly the cycle after the write edge. Writes in consecutive cycles give consecutive pulses, and `launch` is low in any cycle that does not follow a triggering write.
- R6: A command write with bit 0 set does not launch. While the stored command has bit 0 set, a write to 0xA50C (rectangle destination), 0xA97C (line count) or 0xAD7C (polygon count) launches. While bit 0 is clear, those writes do not launch.
- R7: The line count register keeps bits 10:0 as the count and bit 31 as the direction, and reads back with bits 30:11 zero. The polygon count register is stored ANDed with 0x300007FF.
- R8: A read of an unmapped dword offset returns 0xFFFFFFFF. A write to one has no effect on any register and does not launch. The source background (0xA4F8) and source foreground (0xA4FC) exist only in page 0xA4.
- R9: Readback reflects the stored state combinationally. A read in the same cycle as a write to that register returns the old value, and the new value is visible after the write edge.
- R10: Pattern words, colours, line X delta and start, and the four polygon edge registers store and return all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Dword write strobe |
| wr_addr | input | 16 | Write byte address, low two bits ignored |
| wr_data | input | 32 | Write data |
| mem_big | input | 1 | 1 selects the wider base-address mask |
| rd_addr | input | 16 | Read byte address, low two bits ignored |
| rd_data | output | 32 | Packed readback of the addressed register |
| launch | output | 1 | One-cycle engine start strobe |

## Verification
The functions that can coincide are a register write and a readback of that same register through a different alias. A second pair is a command write and the launch strobe from the write in the cycle before. The bench drives a command write while `rd_addr` points at another command alias. It samples readback before the write edge and expects the old word, then samples after the edge and expects the new word. It also issues back-to-back command writes and expects `launch` to stay high for two cycles and then fall.

// File: rtl/gfx2d_pkg.sv
`timescale 1ns/1ps
package gfx2d_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int CRD_W  = 11;
    localparam int STR_W  = 12;
    localparam int BASE_W = 23;

    localparam logic [BASE_W-1:0] BASE_MASK_BIG   = 23'h7FFFF8;
    localparam logic [BASE_W-1:0] BASE_MASK_SMALL = 23'h3FFFF8;
    localparam logic [STR_W-1:0]  STR_MASK        = 12'hFF8;
    localparam logic [DATA_W-1:0] PGCNT_MASK      = 32'h300007FF;
    localparam logic [DATA_W-1:0] UNMAPPED_VAL    = 32'hFFFFFFFF;

    localparam logic [7:0] PG_RECT = 8'hA4;
    localparam logic [7:0] PG_LINE = 8'hA8;
    localparam logic [7:0] PG_POLY = 8'hAC;

    typedef enum logic [4:0] {
        REG_NONE, REG_SRC_BASE, REG_DST_BASE, REG_CLIP_H, REG_CLIP_V, REG_STRIDE,
        REG_PAT0, REG_PAT1, REG_PAT_BG, REG_PAT_FG, REG_SRC_BG, REG_SRC_FG, REG_CMD,
        REG_RECT_SIZE, REG_RECT_SRC, REG_RECT_DST,
        REG_LN_END, REG_LN_DX, REG_LN_X0, REG_LN_Y0, REG_LN_CNT,
        REG_PG_RDX, REG_PG_RX0, REG_PG_LDX, REG_PG_LX0, REG_PG_Y0, REG_PG_CNT
    } reg_id_e;

    typedef struct packed {
        logic [CRD_W-1:0] hi;
        logic [CRD_W-1:0] lo;
    } pair_t;

    typedef struct packed {
        logic [BASE_W-1:0] src_base;
        logic [BASE_W-1:0] dst_base;
        pair_t             clip_h;
        pair_t             clip_v;
        logic [STR_W-1:0]  dst_str;
        logic [STR_W-1:0]  src_str;
        logic [DATA_W-1:0] pat0;
        logic [DATA_W-1:0] pat1;
        logic [DATA_W-1:0] pat_bg;
        logic [DATA_W-1:0] pat_fg;
        logic [DATA_W-1:0] src_bg;
        logic [DATA_W-1:0] src_fg;
        logic [DATA_W-1:0] cmd;
        pair_t             rect_size;
        pair_t             rect_src;
        pair_t             rect_dst;
        pair_t             ln_end;
        logic [DATA_W-1:0] ln_dx;
        logic [DATA_W-1:0] ln_x0;
        logic [CRD_W-1:0]  ln_y0;
        logic [CRD_W-1:0]  ln_cnt;
        logic              ln_dir;
        logic [DATA_W-1:0] pg_rdx;
        logic [DATA_W-1:0] pg_rx0;
        logic [DATA_W-1:0] pg_ldx;
        logic [DATA_W-1:0] pg_lx0;
        logic [CRD_W-1:0]  pg_y0;
        logic [DATA_W-1:0] pg_cnt;
    } regfile_t;

    function automatic reg_id_e decode_addr(logic [ADDR_W-1:0] a);
        logic [7:0] pg;
        logic [7:0] off;
        logic       shared;
        logic       pat_pg;
        pg     = a[15:8];
        off    = {a[7:2], 2'b00};
        shared = (pg == PG_RECT) || (pg == PG_LINE) || (pg == PG_POLY);
        pat_pg = (pg == PG_RECT) || (pg == PG_POLY);
        decode_addr = REG_NONE;
        if (shared) begin
            case (off)
                8'hD4: decode_addr = REG_SRC_BASE;
                8'hD8: decode_addr = REG_DST_BASE;
                8'hDC: decode_addr = REG_CLIP_H;
                8'hE0: decode_addr = REG_CLIP_V;
                8'hE4: decode_addr = REG_STRIDE;
                8'hE8: if (pat_pg) decode_addr = REG_PAT0;
                8'hEC: if (pat_pg) decode_addr = REG_PAT1;
                8'hF0: if (pat_pg) decode_addr = REG_PAT_BG;
                8'hF4: decode_addr = REG_PAT_FG;
                8'hF8: if (pg == PG_RECT) decode_addr = REG_SRC_BG;
                8'hFC: if (pg == PG_RECT) decode_addr = REG_SRC_FG;
                default: decode_addr = REG_NONE;
            endcase
        end else if (pg == PG_RECT + 8'd1) begin
            case (off)
                8'h00: decode_addr = REG_CMD;
                8'h04: decode_addr = REG_RECT_SIZE;
                8'h08: decode_addr = REG_RECT_SRC;
                8'h0C: decode_addr = REG_RECT_DST;
                default: decode_addr = REG_NONE;
            endcase
        end else if (pg == PG_LINE + 8'd1) begin
            case (off)
                8'h00: decode_addr = REG_CMD;
                8'h6C: decode_addr = REG_LN_END;
                8'h70: decode_addr = REG_LN_DX;
                8'h74: decode_addr = REG_LN_X0;
                8'h78: decode_addr = REG_LN_Y0;
                8'h7C: decode_addr = REG_LN_CNT;
                default: decode_addr = REG_NONE;
            endcase
        end else if (pg == PG_POLY + 8'd1) begin
            case (off)
                8'h00: decode_addr = REG_CMD;
                8'h68: decode_addr = REG_PG_RDX;
                8'h6C: decode_addr = REG_PG_RX0;
                8'h70: decode_addr = REG_PG_LDX;
                8'h74: decode_addr = REG_PG_LX0;
                8'h78: decode_addr = REG_PG_Y0;
                8'h7C: decode_addr = REG_PG_CNT;
                default: decode_addr = REG_NONE;
            endcase
        end
    endfunction

    function automatic pair_t split_pair(logic [DATA_W-1:0] d);
        pair_t p;
        p.hi = d[16 +: CRD_W];
        p.lo = d[0 +: CRD_W];
        return p;
    endfunction

    function automatic logic [DATA_W-1:0] join_pair(pair_t p);
        return {{(16-CRD_W){1'b0}}, p.hi, {(16-CRD_W){1'b0}}, p.lo};
    endfunction

    function automatic regfile_t apply_write(regfile_t r, reg_id_e id,
                                             logic [DATA_W-1:0] d, logic big);
        regfile_t          n;
        logic [BASE_W-1:0] bm;
        n  = r;
        bm = big ? BASE_MASK_BIG : BASE_MASK_SMALL;
        case (id)
            REG_SRC_BASE:  n.src_base  = d[BASE_W-1:0] & bm;
            REG_DST_BASE:  n.dst_base  = d[BASE_W-1:0] & bm;
            REG_CLIP_H:    n.clip_h    = split_pair(d);
            REG_CLIP_V:    n.clip_v    = split_pair(d);
            REG_STRIDE: begin
                n.dst_str = d[16 +: STR_W] & STR_MASK;
                n.src_str = d[0 +: STR_W] & STR_MASK;
            end
            REG_PAT0:      n.pat0      = d;
            REG_PAT1:      n.pat1      = d;
            REG_PAT_BG:    n.pat_bg    = d;
            REG_PAT_FG:    n.pat_fg    = d;
            REG_SRC_BG:    n.src_bg    = d;
            REG_SRC_FG:    n.src_fg    = d;
            REG_CMD:       n.cmd       = d;
            REG_RECT_SIZE: n.rect_size = split_pair(d);
            REG_RECT_SRC:  n.rect_src  = split_pair(d);
            REG_RECT_DST:  n.rect_dst  = split_pair(d);
            REG_LN_END:    n.ln_end    = split_pair(d);
            REG_LN_DX:     n.ln_dx     = d;
            REG_LN_X0:     n.ln_x0     = d;
            REG_LN_Y0:     n.ln_y0     = d[CRD_W-1:0];
            REG_LN_CNT: begin
                n.ln_cnt = d[CRD_W-1:0];
                n.ln_dir = d[DATA_W-1];
            end
            REG_PG_RDX:    n.pg_rdx    = d;
            REG_PG_RX0:    n.pg_rx0    = d;
            REG_PG_LDX:    n.pg_ldx    = d;
            REG_PG_LX0:    n.pg_lx0    = d;
            REG_PG_Y0:     n.pg_y0     = d[CRD_W-1:0];
            REG_PG_CNT:    n.pg_cnt    = d & PGCNT_MASK;
            default:       n           = r;
        endcase
        return n;
    endfunction

    function automatic logic [DATA_W-1:0] read_back(regfile_t r, reg_id_e id);
        case (id)
            REG_SRC_BASE:  return {{(DATA_W-BASE_W){1'b0}}, r.src_base};
            REG_DST_BASE:  return {{(DATA_W-BASE_W){1'b0}}, r.dst_base};
            REG_CLIP_H:    return join_pair(r.clip_h);
            REG_CLIP_V:    return join_pair(r.clip_v);
            REG_STRIDE:    return {{(16-STR_W){1'b0}}, r.dst_str,
                                   {(16-STR_W){1'b0}}, r.src_str};
            REG_PAT0:      return r.pat0;
            REG_PAT1:      return r.pat1;
            REG_PAT_BG:    return r.pat_bg;
            REG_PAT_FG:    return r.pat_fg;
            REG_SRC_BG:    return r.src_bg;
            REG_SRC_FG:    return r.src_fg;
            REG_CMD:       return r.cmd;
            REG_RECT_SIZE: return join_pair(r.rect_size);
            REG_RECT_SRC:  return join_pair(r.rect_src);
            REG_RECT_DST:  return join_pair(r.rect_dst);
            REG_LN_END:    return join_pair(r.ln_end);
            REG_LN_DX:     return r.ln_dx;
            REG_LN_X0:     return r.ln_x0;
            REG_LN_Y0:     return {{(DATA_W-CRD_W){1'b0}}, r.ln_y0};
            REG_LN_CNT:    return {r.ln_dir, {(DATA_W-1-CRD_W){1'b0}}, r.ln_cnt};
            REG_PG_RDX:    return r.pg_rdx;
            REG_PG_RX0:    return r.pg_rx0;
            REG_PG_LDX:    return r.pg_ldx;
            REG_PG_LX0:    return r.pg_lx0;
            REG_PG_Y0:     return {{(DATA_W-CRD_W){1'b0}}, r.pg_y0};
            REG_PG_CNT:    return r.pg_cnt;
            default:       return UNMAPPED_VAL;
        endcase
    endfunction

endpackage

// File: rtl/gfx2d_decode.sv
`timescale 1ns/1ps
module gfx2d_decode
    import gfx2d_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           id
);
    always_comb id = decode_addr(addr);
endmodule

// File: rtl/gfx2d_regs.sv
`timescale 1ns/1ps
module gfx2d_regs
    import gfx2d_pkg::*;
#(
    parameter int AE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_id_e           wr_id,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mem_big,
    input  reg_id_e           rd_id,
    output logic [DATA_W-1:0] rd_data,
    output logic              cmd_ae
);
    regfile_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else if (wr_en) regs_q <= apply_write(regs_q, wr_id, wr_data, mem_big);
    end

    always_comb rd_data = read_back(regs_q, rd_id);
    always_comb cmd_ae  = regs_q.cmd[AE_BIT];
endmodule

// File: rtl/gfx2d_launch.sv
`timescale 1ns/1ps
module gfx2d_launch
    import gfx2d_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  reg_id_e wr_id,
    input  logic    wr_ae,
    input  logic    cmd_ae,
    output logic    launch
);
    logic is_final;
    logic fire;

    always_comb begin
        is_final = (wr_id == REG_RECT_DST) || (wr_id == REG_LN_CNT) ||
                   (wr_id == REG_PG_CNT);
        if (wr_id == REG_CMD) fire = wr_en && !wr_ae;
        else                  fire = wr_en && is_final && cmd_ae;
    end

    always_ff @(posedge clk) begin
        if (rst) launch <= 1'b0;
        else     launch <= fire;
    end
endmodule

// File: rtl/gfx2d_regfile.sv
`timescale 1ns/1ps
module gfx2d_regfile
    import gfx2d_pkg::*;
#(
    parameter int AE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mem_big,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              launch
);
    localparam int NPORT = 2;

    logic [ADDR_W-1:0] dec_addr [NPORT];
    reg_id_e           dec_id   [NPORT];
    reg_id_e           wr_id;
    reg_id_e           rd_id;
    logic              cmd_ae;

    assign dec_addr[0] = wr_addr;
    assign dec_addr[1] = rd_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        gfx2d_decode u_dec (.addr(dec_addr[p]), .id(dec_id[p]));
    end

    assign wr_id = dec_id[0];
    assign rd_id = dec_id[1];

    gfx2d_regs #(.AE_BIT(AE_BIT)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_id(wr_id), .wr_data(wr_data),
        .mem_big(mem_big), .rd_id(rd_id), .rd_data(rd_data), .cmd_ae(cmd_ae)
    );

    gfx2d_launch u_launch (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_id(wr_id),
        .wr_ae(wr_data[AE_BIT]), .cmd_ae(cmd_ae), .launch(launch)
    );
endmodule

// File: rtl/gfx2d_regfile_chk.sv
`timescale 1ns/1ps
module gfx2d_regfile_chk
    import gfx2d_pkg::*;
#(
    parameter int AE_BIT = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input reg_id_e           wr_id,
    input logic [DATA_W-1:0] wr_data,
    input reg_id_e           rd_id,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              launch
);
    AST_CMD_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_id == REG_CMD && !wr_data[AE_BIT]) |=> launch); // R5

    AST_ARMED_CMD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_id == REG_CMD && wr_data[AE_BIT]) |=> !launch); // R6

    AST_IDLE_NO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !launch); // R5

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (rd_id == REG_SRC_BASE || rd_id == REG_DST_BASE)
            |-> (rd_data[2:0] == 3'b000 && rd_data[31:23] == 9'd0)); // R3

    AST_LNCNT_GAP: assert property (@(posedge clk) disable iff (rst)
        (rd_id == REG_LN_CNT) |-> (rd_data[30:11] == 20'd0)); // R7

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(rd_addr) |-> $stable(rd_data))); // R9
endmodule

bind gfx2d_regfile gfx2d_regfile_chk #(.AE_BIT(AE_BIT)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_id(wr_id), .wr_data(wr_data),
    .rd_id(rd_id), .rd_addr(rd_addr), .rd_data(rd_data), .launch(launch)
);

// File: tb/test_gfx2d_regfile.sv
`timescale 1ns/1ps
module test_gfx2d_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        mem_big = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        launch;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit ae_q = 0;

    localparam logic [31:0] PATS [4] = '{32'hFFFFFFFF, 32'h00000000,
                                         32'h5A3C96E1, 32'hA5C3691E};
    localparam logic [7:0] PGS [3] = '{8'hA4, 8'hA8, 8'hAC};

    gfx2d_regfile i_gfx2d_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mem_big(mem_big), .rd_addr(rd_addr), .rd_data(rd_data), .launch(launch)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [15:0] a, logic [31:0] exp, string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    function automatic bit is_cmd(logic [15:0] a);
        return a == 16'hA500 || a == 16'hA900 || a == 16'hAD00;
    endfunction

    function automatic bit is_final(logic [15:0] a);
        return a == 16'hA50C || a == 16'hA97C || a == 16'hAD7C;
    endfunction

    // One write; checks launch in the cycle after the write edge (R5 R6)
    task automatic wr(logic [15:0] a, logic [31:0] d, string tag);
        bit exp_l;
        exp_l = is_cmd(a) ? !d[0] : (is_final(a) && ae_q);
        if (is_cmd(a)) ae_q = d[0];
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk({tag, " launch"}, {31'd0, launch}, {31'd0, exp_l});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 launch", {31'd0, launch}, 32'd0);
        rd(16'hA4D4, 32'd0, "R1 src base");
        rd(16'hAD00, 32'd0, "R1 cmd");
        rd(16'hA97C, 32'd0, "R1 line count");
        rd(16'hACF4, 32'd0, "R1 pattern fg");

        // R2 R3 base masking across aliases and memory sizes
        for (int w = 0; w < 3; w++)
            for (int m = 0; m < 2; m++)
                for (int p = 0; p < 4; p++) begin
                    logic [31:0] mk;
                    mk = m ? 32'h7FFFF8 : 32'h3FFFF8;
                    mem_big = m[0];
                    wr({PGS[w], 8'hD4}, PATS[p], "R3 src base");
                    wr({PGS[w], 8'hD8}, ~PATS[p], "R3 dst base");
                    for (int r = 0; r < 3; r++) begin
                        rd({PGS[r], 8'hD4}, PATS[p] & mk, "R2 R3 src base");
                        rd({PGS[r], 8'hD8}, ~PATS[p] & mk, "R2 R3 dst base");
                    end
                end
        mem_big = 1'b1;
        wr(16'hA8D4, 32'h00FFFFFF, "R3 big");
        mem_big = 1'b0;
        rd(16'hACD4, 32'h007FFFF8, "R3 mask kept");

        // R2 R4 packed pairs and strides
        for (int w = 0; w < 3; w++)
            for (int p = 0; p < 4; p++) begin
                logic [31:0] d, ep, es;
                d  = PATS[p] ^ (32'h01230123 * w);
                ep = (((d >> 16) & 32'h7FF) << 16) | (d & 32'h7FF);
                es = (((d >> 16) & 32'hFF8) << 16) | (d & 32'hFF8);
                wr({PGS[w], 8'hDC}, d, "R4 clip h");
                wr({PGS[w], 8'hE0}, ~d, "R4 clip v");
                wr({PGS[w], 8'hE4}, d, "R4 stride");
                rd({PGS[(w+1)%3], 8'hDC}, ep, "R2 R4 clip h");
                rd({PGS[(w+2)%3], 8'hE0},
                   ((((~d) >> 16) & 32'h7FF) << 16) | ((~d) & 32'h7FF), "R2 R4 clip v");
                rd({PGS[(w+1)%3], 8'hE4}, es, "R2 R4 stride");
                wr(16'hA508, d, "R4 rect src");
                rd(16'hA508, ep, "R4 rect src");
            end

        // R10 full-width registers, R2 pattern aliases
        wr(16'hA8F4, 32'hDEADBEEF, "R10 fg");
        rd(16'hA4F4, 32'hDEADBEEF, "R2 R10 fg via rect");
        rd(16'hACF4, 32'hDEADBEEF, "R2 R10 fg via poly");
        wr(16'hACE8, 32'h13579BDF, "R10 pat0");
        rd(16'hA4E8, 32'h13579BDF, "R2 R10 pat0");
        wr(16'hA970, 32'h80000001, "R10 line dx");
        rd(16'hA970, 32'h80000001, "R10 line dx");
        wr(16'hAD74, 32'hFEDCBA98, "R10 poly left x");
        rd(16'hAD74, 32'hFEDCBA98, "R10 poly left x");

        // R7 count fields
        wr(16'hA97C, 32'hFFFFFFFF, "R7 line count");
        rd(16'hA97C, 32'h800007FF, "R7 line count");
        wr(16'hA97C, 32'h7FFFF800, "R7 line count zero");
        rd(16'hA97C, 32'h00000000, "R7 line count zero");
        wr(16'hAD7C, 32'hFFFFFFFF, "R7 poly count");
        rd(16'hAD7C, 32'h300007FF, "R7 poly count");

        // R8 unmapped and single-window registers
        wr(16'hA4F8, 32'h22222222, "R8 src bg");
        wr(16'hA8F8, 32'h11111111, "R8 unmapped alias");
        rd(16'hA4F8, 32'h22222222, "R8 src bg untouched");
        rd(16'hA8F8, 32'hFFFFFFFF, "R8 unmapped alias read");
        rd(16'hA8E8, 32'hFFFFFFFF, "R8 line page pattern");
        rd(16'hA4C0, 32'hFFFFFFFF, "R8 unmapped read");
        wr(16'h1234, 32'h0, "R8 low unmapped");
        rd(16'h1234, 32'hFFFFFFFF, "R8 low unmapped read");

        // R5 immediate launch via each command alias
        wr(16'hA500, 32'h00000010, "R5 cmd rect");
        wr(16'hA900, 32'h00000020, "R5 cmd line");
        wr(16'hAD00, 32'h00000030, "R5 cmd poly");
        rd(16'hA500, 32'h00000030, "R2 cmd alias");
        @(negedge clk);
        chk("R5 single pulse", {31'd0, launch}, 32'd0);
        // R6 deferred launch
        wr(16'hA900, 32'h00000041, "R6 armed cmd");
        wr(16'hA504, 32'h12345678, "R6 rect size");
        wr(16'hA50C, 32'h00100020, "R6 rect dst");
        wr(16'hA97C, 32'h00000005, "R6 line count");
        wr(16'hAD7C, 32'h00000007, "R6 poly count");
        wr(16'hA978, 32'h00000003, "R6 line y");
        wr(16'hA500, 32'h00000040, "R6 disarm");
        wr(16'hA50C, 32'h00200010, "R6 unarmed dst");
        wr(16'hAD7C, 32'h00000001, "R6 unarmed count");

        // R5 back-to-back pulses
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'hA500; wr_data = 32'h2;
        @(negedge clk);
        wr_addr = 16'hAD00; wr_data = 32'h4;
        chk("R5 first pulse", {31'd0, launch}, 32'd1);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5 second pulse", {31'd0, launch}, 32'd1);
        @(negedge clk);
        chk("R5 pulse ends", {31'd0, launch}, 32'd0);

        // R9 same-cycle write and readback through another alias
        rd_addr = 16'hA900;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'hAD00; wr_data = 32'h0000ABC0;
        #1;
        chk("R9 old value same cycle", rd_data, 32'h4);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 new value", rd_data, 32'h0000ABC0);
        chk("R9 R5 launch", {31'd0, launch}, 32'd1);
        ae_q = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule